// File: doc/BRIEF.md
# Two-Stage Programmable Clock Divider

This block derives two divided clocks from one input clock. A power-of-two prescaler (divide by 1, 2, 4, 8 or 16) feeds a final stage that divides by 2 or 4. The product of the two gives the main output ratio, which runs from 2 to 64. A companion output runs at half the main rate. One control register holds both divide selects and a stop bit for each output. A read-only status word reports the effective ratio, a sticky illegal-setting flag and whether the block is enabled.

Both outputs are registered and have a 50% duty cycle. A stop or restart only takes effect while the output in question is low, so every high pulse has its full length. A new ratio is adopted when the internal main phase next rises, which is the start of a new output period. Writes with an unsupported divide encoding are rejected as a whole and set the sticky flag. The companion output is held off whenever the prescaler divides by 4 or more.

Top module: `clkdiv_pair`

## Requirements
- R1: After a synchronous active-low reset the control word reads 0x0301: both stop bits set, prescaler code 0, final code 1, ratio 4. Both outputs are low and the status word reads 0x0004.
- R2: The control word holds the prescaler code in bits 4:2 (codes 0..4 give divide 1,2,4,8,16) and the final code in bits 1:0 (0 gives divide 2, 1 gives divide 4). The main output period is the product of the two in input cycles, with the output high for exactly half of it.
- R3: The companion output has twice the main period and 50% duty. It runs only when bit 9 is 0 and the prescaler code is 0 or 1. Otherwise it stays low.
- R4: A write to address 0 with a legal encoding stores all 16 bits, and they read back unchanged at address 0.
- R5: A write to address 0 with a prescaler code of 5..7 or a final code of 2..3 leaves the control word unchanged and sets the error flag. The flag stays set until reset.
- R6: Bit 8 stops the main output and bit 9 stops the companion. Gating changes only while the output is low, so no high pulse is ever shortened or lengthened.
- R7: A ratio written mid-period takes effect at the next rise of the internal main phase. The output follows that phase one cycle later.
- R8: The status word at address 1 holds the ratio in bits 6:0, the error flag in bit 7, and in bit 8 a 1 exactly when both stop bits are 0.
- R9: Writes to address 1 have no effect on either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | 0 = control word, 1 = status word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed word (combinational) |
| clk_main_o | output | 1 | Main divided clock |
| clk_comp_o | output | 1 | Companion clock at half the main rate |

## Verification
A single write can change a stop bit and the ratio at once. That write can land in the same cycle as the phase rise that adopts a new ratio, or in the cycle that freezes the gate for the coming high pulse. The bench provokes this by sweeping the write offset across every cycle of the period and by alternating writes that flip stop bits and divide fields together. A behavioural per-clock model judges each output on every cycle, and directed period and duty measurements back it up.

// File: rtl/clkdiv_pkg.sv
// Shared field positions, widths and ratio helpers for the two-stage divider.
// Assumes prescaler codes 0..PRE_CODE_MAX and final-stage codes 0..1.
package clkdiv_pkg;
    localparam int CTRL_W        = 16;
    localparam int ADDR_W        = 1;
    localparam int PRE_LSB       = 2;
    localparam int PRE_W         = 3;
    localparam int FIN_LSB       = 0;
    localparam int FIN_W         = 2;
    localparam int STOP_MAIN_BIT = 8;
    localparam int STOP_COMP_BIT = 9;
    localparam int PRE_CODE_MAX  = 4;
    localparam int COMP_PRE_MAX  = 1;
    localparam int FIN_CODE_MAX  = 1;
    localparam int HALF_W        = PRE_CODE_MAX + 2;
    localparam int RATIO_W       = HALF_W + 1;
    localparam int STAT_ERR_BIT  = RATIO_W;
    localparam int STAT_EN_BIT   = RATIO_W + 1;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = '0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(1);
    localparam logic [CTRL_W-1:0] CTRL_RST  = 16'h0301;

    // Legal encodings: prescaler code in range, final code 0 or 1.
    function automatic logic code_legal(input logic [PRE_W-1:0] pre,
                                        input logic [FIN_W-1:0] fin);
        return (int'(pre) <= PRE_CODE_MAX) && (int'(fin) <= FIN_CODE_MAX);
    endfunction

    // Half of the overall ratio, in input cycles.
    function automatic logic [HALF_W-1:0] half_of(input logic [PRE_W-1:0] pre,
                                                  input logic [FIN_W-1:0] fin);
        logic [HALF_W-1:0] h;
        h = HALF_W'(1) << pre;
        if (fin[0]) h = h << 1;
        return h;
    endfunction

    localparam logic [HALF_W-1:0] HALF_RST =
        half_of(CTRL_RST[PRE_LSB +: PRE_W], CTRL_RST[FIN_LSB +: FIN_W]);
endpackage

// File: rtl/clkdiv_regs.sv
// Control and status words. Rejects writes with unsupported divide encodings
// and latches a sticky error flag. Assumes a single-cycle write strobe.
module clkdiv_regs
    import clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] rdata,
    output logic [PRE_W-1:0]  pre_o,
    output logic [FIN_W-1:0]  fin_o,
    output logic              stop_main_o,
    output logic              stop_comp_o
);
    logic [CTRL_W-1:0] ctrl_q;
    logic              err_q;
    logic              wr_ctrl;
    logic              wr_ok;
    logic [CTRL_W-1:0] stat_w;

    assign wr_ctrl = wr_en && (addr == ADDR_CTRL);
    assign wr_ok   = code_legal(wdata[PRE_LSB +: PRE_W], wdata[FIN_LSB +: FIN_W]);

    // Store a legal control word or flag an illegal one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            err_q  <= 1'b0;
        end else if (wr_ctrl) begin
            if (wr_ok) ctrl_q <= wdata;
            else       err_q  <= 1'b1;
        end
    end

    assign pre_o       = ctrl_q[PRE_LSB +: PRE_W];
    assign fin_o       = ctrl_q[FIN_LSB +: FIN_W];
    assign stop_main_o = ctrl_q[STOP_MAIN_BIT];
    assign stop_comp_o = ctrl_q[STOP_COMP_BIT];

    // Assemble the read-only status word.
    always_comb begin
        stat_w = '0;
        stat_w[RATIO_W-1:0] = RATIO_W'(half_of(pre_o, fin_o)) << 1;
        stat_w[STAT_ERR_BIT] = err_q;
        stat_w[STAT_EN_BIT]  = !stop_main_o && !stop_comp_o;
    end

    // Read mux.
    assign rdata = (addr == ADDR_CTRL) ? ctrl_q : stat_w;

    p_fields_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        code_legal(pre_o, fin_o));
    p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    p_reject_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wr_ok) |=> $stable(ctrl_q));
    p_stat_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_STAT) |=> $stable(ctrl_q));
endmodule

// File: rtl/clkdiv_phase.sv
// Half-period counter producing the free-running main and companion phases.
// A pending half ratio is adopted only when the main phase rises.
module clkdiv_phase
    import clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] pend_half_i,
    output logic              ph_main_o,
    output logic              ph_comp_o
);
    logic [HALF_W-1:0] cnt_q;
    logic [HALF_W-1:0] act_half_q;
    logic              last_w;
    logic              rise_w;

    assign last_w = (cnt_q == act_half_q - HALF_W'(1));
    assign rise_w = last_w && !ph_main_o;

    // Count half periods, toggle phases, adopt new ratio at a rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            act_half_q <= HALF_RST;
            ph_main_o  <= 1'b0;
            ph_comp_o  <= 1'b0;
        end else if (last_w) begin
            cnt_q     <= '0;
            ph_main_o <= !ph_main_o;
            if (rise_w) begin
                act_half_q <= pend_half_i;
                ph_comp_o  <= !ph_comp_o;
            end
        end else begin
            cnt_q <= cnt_q + HALF_W'(1);
        end
    end

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < act_half_q);
    p_ratio_at_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_half_q) |-> $rose(ph_main_o));
    p_comp_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ph_comp_o) |-> $rose(ph_main_o));
endmodule

// File: rtl/clkdiv_gate.sv
// Glitch-free gate: samples the run request only while the phase is low and
// registers the gated output, so high pulses are always whole.
module clkdiv_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_i,
    input  logic run_i,
    output logic clk_o
);
    logic en_q;

    // Freeze enable during high phases; register gated output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            clk_o <= 1'b0;
        end else begin
            clk_o <= phase_i && en_q;
            if (!phase_i) en_q <= run_i;
        end
    end

    p_rise_whole_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_o) |-> $past(phase_i));
    p_fall_whole_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_o) |-> !$past(phase_i));
endmodule

// File: rtl/clkdiv_pair.sv
// Top: register block, phase generator and one gate per output.
// Assumes all logic runs in the input clock domain.
module clkdiv_pair
    import clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CTRL_W-1:0] bus_wdata,
    output logic [CTRL_W-1:0] bus_rdata,
    output logic              clk_main_o,
    output logic              clk_comp_o
);
    logic [PRE_W-1:0] pre_w;
    logic [FIN_W-1:0] fin_w;
    logic             stop_main_w;
    logic             stop_comp_w;
    logic             ph_main_w;
    logic             ph_comp_w;
    logic             run_comp_w;

    clkdiv_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .pre_o(pre_w), .fin_o(fin_w),
        .stop_main_o(stop_main_w), .stop_comp_o(stop_comp_w)
    );

    clkdiv_phase u_phase (
        .clk(clk), .rst_n(rst_n), .pend_half_i(half_of(pre_w, fin_w)),
        .ph_main_o(ph_main_w), .ph_comp_o(ph_comp_w)
    );

    // Companion may run only at the two fastest prescaler settings.
    assign run_comp_w = !stop_comp_w && (int'(pre_w) <= COMP_PRE_MAX);

    clkdiv_gate u_gate_main (
        .clk(clk), .rst_n(rst_n), .phase_i(ph_main_w),
        .run_i(!stop_main_w), .clk_o(clk_main_o)
    );

    clkdiv_gate u_gate_comp (
        .clk(clk), .rst_n(rst_n), .phase_i(ph_comp_w),
        .run_i(run_comp_w), .clk_o(clk_comp_o)
    );
endmodule

// File: tb/tb_clkdiv_pair.sv
module tb_clkdiv_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [0:0]  bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        clk_main_o, clk_comp_o;
    int tests = 0, fails = 0;
    bit done = 0;

    clkdiv_pair dut (.*);

    always #5 clk = ~clk;

    // Behavioural reference state
    int m_reg, m_err, hc, ah, ph, pc, em, ec, om, oc;

    function automatic int half_ref(int w);
        int p, f;
        p = (w >> 2) & 7; f = w & 3;
        return (1 << p) * ((f == 1) ? 2 : 1);
    endfunction

    always @(posedge clk) begin
        int n_om, n_oc, n_em, n_ec, want_m, want_c, pend;
        if (!rst_n) begin
            m_reg = 'h0301; m_err = 0; hc = 0; ah = 2; ph = 0; pc = 0;
            em = 0; ec = 0; om = 0; oc = 0;
        end else begin
            pend   = half_ref(m_reg);
            want_m = ((m_reg >> 8) & 1) == 0;
            want_c = (((m_reg >> 9) & 1) == 0) && (((m_reg >> 2) & 7) <= 1);
            n_om = ph & em; n_oc = pc & ec;
            n_em = ph ? em : want_m;
            n_ec = pc ? ec : want_c;
            if (hc == ah - 1) begin
                hc = 0;
                if (ph == 0) begin ah = pend; pc = 1 - pc; end
                ph = 1 - ph;
            end else hc++;
            om = n_om; oc = n_oc; em = n_em; ec = n_ec;
            if (bus_wr && bus_addr == 1'b0) begin
                if (((bus_wdata >> 2) & 7) <= 4 && (bus_wdata & 3) <= 1)
                    m_reg = int'(bus_wdata);
                else m_err = 1;
            end
        end
    end

    // Per-clock comparison of both outputs
    always @(negedge clk) if (rst_n && !done) begin
        tests += 2;
        if (clk_main_o !== om[0]) begin
            fails++; $display("FAIL R2 R6 R7 main: actual %0b expected %0d at %0t", clk_main_o, om, $time);
        end
        if (clk_comp_o !== oc[0]) begin
            fails++; $display("FAIL R3 R6 comp: actual %0b expected %0d at %0t", clk_comp_o, oc, $time);
        end
    end

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++; $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(bit a, int d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = 16'(d);
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(bit a, output int v);
        @(negedge clk); bus_addr = a; #1 v = int'(bus_rdata);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic bit sig(bit comp);
        return comp ? clk_comp_o : clk_main_o;
    endfunction

    task automatic measure(bit comp, output int per, output int hi);
        bit prev, cur, hit;
        int n;
        prev = sig(comp); hit = 0; n = 0; per = 0; hi = 0;
        while (!hit && n < 1000) begin
            @(negedge clk); cur = sig(comp); n++;
            hit = !prev && cur; prev = cur;
        end
        hi = 1; hit = 0;
        while (!hit && per < 1000) begin
            @(negedge clk); cur = sig(comp); per++;
            hit = !prev && cur;
            if (cur && !hit) hi++;
            prev = cur;
        end
    endtask

    task automatic low_for(bit comp, int cycles, string req);
        int highs = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk); if (sig(comp)) highs++;
        end
        check(req, highs, 0);
    endtask

    initial begin
        int v, per, hi;
        do_reset();
        // R1 reset state
        rd(0, v); check("R1 ctrl", v, 'h0301);
        rd(1, v); check("R1 status", v, 'h0004);
        check("R1 main low", clk_main_o, 0);
        check("R1 comp low", clk_comp_o, 0);
        // R2 R3 ratio 4 with companion
        wr(0, 'h0001);
        rd(1, v); check("R8 status run", v, 'h0104);
        measure(0, per, hi); check("R2 period 4", per, 4); check("R2 high 4", hi, 2);
        measure(1, per, hi); check("R3 comp period 8", per, 8); check("R3 comp high", hi, 4);
        // ratio 2
        wr(0, 'h0000);
        repeat (10) @(negedge clk);
        measure(0, per, hi); check("R2 period 2", per, 2); check("R2 high 2", hi, 1);
        measure(1, per, hi); check("R3 comp period 4", per, 4);
        // ratio 64
        wr(0, 'h0011);
        measure(0, per, hi); measure(0, per, hi);
        check("R2 period 64", per, 64); check("R2 high 64", hi, 32);
        // R3 companion forced off at prescaler code 2
        wr(0, 'h0008);
        repeat (20) @(negedge clk);
        low_for(1, 64, "R3 comp off pre2");
        measure(0, per, hi); check("R2 period 8", per, 8);
        // R6 main stop
        wr(0, 'h0104);
        repeat (10) @(negedge clk);
        low_for(0, 40, "R6 main stopped");
        rd(1, v); check("R8 status stopped", v, 'h0004);
        // R4 full-word store
        wr(0, 'hF00D);
        rd(0, v); check("R4 readback", v, 'hF00D);
        // R5 illegal writes
        wr(0, 'h0014);
        rd(0, v); check("R5 pre illegal keeps", v, 'hF00D);
        wr(0, 'h0002);
        rd(0, v); check("R5 fin illegal keeps", v, 'hF00D);
        rd(1, v); check("R5 R8 status err", v, 'h01A0);
        measure(0, per, hi); measure(0, per, hi); check("R5 ratio kept", per, 32);
        // R9 status write ignored
        wr(1, 'h0000);
        rd(1, v); check("R9 status kept", v, 'h01A0);
        rd(0, v); check("R9 ctrl kept", v, 'hF00D);
        // R6 R7 sweep writes across the period; model checks each clock
        for (int off = 0; off < 16; off++) begin
            wr(0, (off % 2) ? 'h0204 : 'h0001);
            repeat (off) @(negedge clk);
            wr(0, (off % 3 == 0) ? 'h0100 : ((off % 3 == 1) ? 'h0005 : 'h0000));
            repeat (40) @(negedge clk);
        end
        // R5 err cleared only by reset
        do_reset();
        rd(1, v); check("R5 err cleared by reset", v, 'h0004);
        repeat (5) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1; fails++; tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule